// File: doc/BRIEF.md
# Activity-Driven Clock Rate Controller

This block produces the clock-enable pulse train that sets a processor core's effective rate. In the fast state the enable is high on every base clock. In the slow state it is high on one base clock out of every n+1, where n is a programmable 8-bit divider value. Cutting the enable rate by a factor of n+1 cuts the core's dynamic activity by the same factor.

A two-bit policy field picks how the rate is chosen. The core can be held fast, held slow, or left to follow live activity. Under the activity-following policy, any set per-thread busy flag selects the fast state. A wake request from a timer or an unbuffered port also selects it, because such a request makes a thread runnable. With no activity at all, the block drops to the slow state. Timers and ports keep running in the slow state, so either one can bring the core back to full speed.

Leaving the slow state happens at the very next base clock edge. The block does not wait for the current divided period to finish. Entering the slow state takes effect once the current enable pulse has completed. Writing the divider restarts the countdown from the new value.

Top module: `rate_governor`

## Requirements
- R1: After synchronous reset, the enable is high, the slow-state status is 0, the countdown output is 0, the policy field is 00 and the divider is 0.
- R2: With policy 00, the enable is high on every cycle and the status stays 0, whatever the thread and wake inputs do.
- R3: With policy 01, the block stays in the slow state and the enable pulses exactly once every n+1 cycles, where n is the divider value.
- R4: A divider value of 0 gives one enable per cycle in the slow state, while the status still reads 1.
- R5: With policy 11, the block is fast while any bit of the thread busy vector is 1 and slow while all bits are 0. The state is re-evaluated on every edge.
- R6: Under policy 11, a one-cycle request on any timer wake bit or port wake bit forces the fast state for the following cycle.
- R7: Policy 10 behaves exactly like policy 00.
- R8: Slow-to-fast: in the cycle after the edge at which the fast state is requested, the enable is high and the status is 0, even in the middle of a divided period.
- R9: Fast-to-slow: the first slow cycle shows the countdown at n with the enable low (for n>0). The next enable follows n cycles later.
- R10: A divider write while slow reloads the countdown with the written value on the next cycle. The following enable comes that many cycles later.
- R11: The status output is 1 exactly in the cycles running at the divided rate. It changes in the same cycle as the enable pattern. The countdown output reads 0 whenever the status is 0.
- R12: A divider value of 99 yields exactly 3 enables in any 300 consecutive slow cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div_we | input | 1 | Divider write strobe |
| cfg_div_data | input | DW (8) | Divider value n to write |
| cfg_mode_we | input | 1 | Policy write strobe |
| cfg_mode_data | input | 2 | Policy: 00 fast, 01 slow, 10 fast (reserved), 11 follow activity |
| thread_active | input | NT (8) | Per-thread busy flags |
| timer_wake | input | NTM (4) | Timer wake requests |
| port_wake | input | NP (4) | Unbuffered port wake requests |
| core_clk_en | output | 1 | Clock enable for the core |
| standby_stat | output | 1 | 1 while running at the divided rate |
| div_count | output | DW (8) | Current countdown value of the divider |

## Verification
The bound checker tracks the policy and divider writes itself. On every cycle it checks the following:
- the policy decides the next state;
- a fast cycle always carries an enable and a zero count;
- the count steps down by one between reloads;
- entering the slow state or writing the divider loads exactly the divider value.

Only the bench's scenarios can show pulse rates over long windows, such as one in a hundred at n=99 or full rate at n=0. The same holds for the exact cycle of the first enable after entering the slow state or after a reload, and for the reset values seen at the ports.

// File: rtl/rg_pkg.sv
`timescale 1ns/1ps
// Package: shared policy encoding for the rate governor.
// Assumes the policy field is two bits wide; 10 is reserved and decodes as fast.
package rg_pkg;

    typedef enum logic [1:0] {
        POL_FAST   = 2'b00,
        POL_SLOW   = 2'b01,
        POL_RSVD   = 2'b10,
        POL_FOLLOW = 2'b11
    } rate_policy_e;

    // Decide whether the divided rate is wanted for a policy and activity level.
    function automatic logic slow_wanted(input rate_policy_e pol, input logic busy);
        case (pol)
            POL_SLOW:   return 1'b1;
            POL_FOLLOW: return ~busy;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rg_activity.sv
`timescale 1ns/1ps
// Module: rg_activity
// Folds thread busy flags and wake requests from timers and ports into one
// activity bit. Assumes all inputs are already synchronous to clk.
module rg_activity #(
    parameter int NT  = 8,
    parameter int NTM = 4,
    parameter int NP  = 4
) (
    input  logic [NT-1:0]  thread_active,
    input  logic [NTM-1:0] timer_wake,
    input  logic [NP-1:0]  port_wake,
    output logic           any_busy
);
    localparam int NSRC = NT + NTM + NP;

    logic [NSRC-1:0] src;
    logic [NSRC:0]   chain;

    // Collect every activity source into one flat vector.
    always_comb src = {port_wake, timer_wake, thread_active};

    assign chain[0] = 1'b0;
    // OR chain across all sources, one stage per source.
    for (genvar i = 0; i < NSRC; i++) begin : g_or
        assign chain[i+1] = chain[i] | src[i];
    end

    assign any_busy = chain[NSRC];
endmodule

// File: rtl/rg_cfg_regs.sv
`timescale 1ns/1ps
// Module: rg_cfg_regs
// Holds the divider value and the rate policy. It also gives the divider value
// as it will stand after this edge, so a same-cycle write is seen at once.
// Assumes write strobes are single-cycle and synchronous.
module rg_cfg_regs
    import rg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          div_we,
    input  logic [DW-1:0] div_data,
    input  logic          mode_we,
    input  logic [1:0]    mode_data,
    output logic [DW-1:0] div_q,
    output logic [DW-1:0] div_next,
    output logic          div_written,
    output rate_policy_e  policy_q
);
    // Divider storage register.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_we) div_q <= div_data;
    end

    // Policy storage register.
    always_ff @(posedge clk) begin
        if (!rst_n)       policy_q <= POL_FAST;
        else if (mode_we) policy_q <= rate_policy_e'(mode_data);
    end

    // Forward a write in progress so the countdown can load the fresh value.
    always_comb begin
        div_next    = div_we ? div_data : div_q;
        div_written = div_we;
    end
endmodule

// File: rtl/rg_enable_gen.sv
`timescale 1ns/1ps
// Module: rg_enable_gen
// Tracks fast/slow state and the divided countdown and produces the enable.
// Slow-to-fast takes effect on the next edge. Fast-to-slow loads the countdown
// with n after the current (single-cycle) pulse, spacing pulses n+1 apart.
// Assumes want_slow is settled before each edge.
module rg_enable_gen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          want_slow,
    input  logic [DW-1:0] div_q,
    input  logic [DW-1:0] div_next,
    input  logic          div_written,
    output logic          en,
    output logic          slow,
    output logic [DW-1:0] cnt
);
    logic          slow_q;
    logic [DW-1:0] cnt_q;
    logic          at_zero;

    // Detect the end of a divided period.
    always_comb at_zero = (cnt_q == '0);

    // State and countdown update with priority: leave slow, load, wrap, count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!want_slow) begin
            slow_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!slow_q || div_written) begin
            slow_q <= 1'b1;
            cnt_q  <= div_next;
        end else if (at_zero) begin
            cnt_q  <= div_q;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Enable is continuous when fast, once per period when slow.
    always_comb begin
        en   = !slow_q || at_zero;
        slow = slow_q;
        cnt  = cnt_q;
    end
endmodule

// File: rtl/rate_governor.sv
`timescale 1ns/1ps
// Module: rate_governor (top)
// Produces the core clock enable at full rate or at 1/(n+1) of full rate,
// as picked by the policy field and live thread/wake activity.
// Assumes a single clock domain and synchronous active-low reset.
module rate_governor
    import rg_pkg::*;
#(
    parameter int NT  = 8,
    parameter int NTM = 4,
    parameter int NP  = 4,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_div_we,
    input  logic [DW-1:0]  cfg_div_data,
    input  logic           cfg_mode_we,
    input  logic [1:0]     cfg_mode_data,
    input  logic [NT-1:0]  thread_active,
    input  logic [NTM-1:0] timer_wake,
    input  logic [NP-1:0]  port_wake,
    output logic           core_clk_en,
    output logic           standby_stat,
    output logic [DW-1:0]  div_count
);
    logic          any_busy;
    logic [DW-1:0] div_q;
    logic [DW-1:0] div_next;
    logic          div_written;
    rate_policy_e  policy_q;
    logic          want_slow;

    rg_activity #(.NT(NT), .NTM(NTM), .NP(NP)) u_act (
        .thread_active (thread_active),
        .timer_wake    (timer_wake),
        .port_wake     (port_wake),
        .any_busy      (any_busy)
    );

    rg_cfg_regs #(.DW(DW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_we      (cfg_div_we),
        .div_data    (cfg_div_data),
        .mode_we     (cfg_mode_we),
        .mode_data   (cfg_mode_data),
        .div_q       (div_q),
        .div_next    (div_next),
        .div_written (div_written),
        .policy_q    (policy_q)
    );

    // Policy decision from the stored policy and current activity.
    always_comb want_slow = slow_wanted(policy_q, any_busy);

    rg_enable_gen #(.DW(DW)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_slow   (want_slow),
        .div_q       (div_q),
        .div_next    (div_next),
        .div_written (div_written),
        .en          (core_clk_en),
        .slow        (standby_stat),
        .cnt         (div_count)
    );
endmodule

// File: rtl/rate_governor_chk.sv
`timescale 1ns/1ps
// Module: rate_governor_chk
// Port-level checker bound to rate_governor. It keeps its own copy of the
// policy and divider from the write strobes.
module rate_governor_chk #(
    parameter int NT  = 8,
    parameter int NTM = 4,
    parameter int NP  = 4,
    parameter int DW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_div_we,
    input logic [DW-1:0]  cfg_div_data,
    input logic           cfg_mode_we,
    input logic [1:0]     cfg_mode_data,
    input logic [NT-1:0]  thread_active,
    input logic [NTM-1:0] timer_wake,
    input logic [NP-1:0]  port_wake,
    input logic           core_clk_en,
    input logic           standby_stat,
    input logic [DW-1:0]  div_count
);
    logic [1:0]    pol_sh;
    logic [DW-1:0] div_sh;
    logic          busy;

    // Shadow copies of the configuration as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_sh <= 2'b00;
            div_sh <= '0;
        end else begin
            if (cfg_mode_we) pol_sh <= cfg_mode_data;
            if (cfg_div_we)  div_sh <= cfg_div_data;
        end
    end

    // Any activity source seen at the ports.
    always_comb busy = (|thread_active) || (|timer_wake) || (|port_wake);

    p_fast_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_stat |-> core_clk_en);

    p_forced_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_sh[0] == 1'b0) |=> !standby_stat);

    p_forced_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_sh == 2'b01) |=> standby_stat);

    p_follow_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_sh == 2'b11 && busy) |=> !standby_stat);

    p_follow_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_sh == 2'b11 && !busy) |=> standby_stat);

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_stat && $past(standby_stat) && !$past(cfg_div_we)
         && $past(div_count) != '0) |-> div_count == $past(div_count) - 1'b1);

    p_fast_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_stat |-> div_count == '0);

    p_entry_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby_stat) |-> div_count == div_sh);

    p_write_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_stat && $past(standby_stat) && $past(cfg_div_we))
        |-> div_count == div_sh);
endmodule

bind rate_governor rate_governor_chk #(.NT(NT), .NTM(NTM), .NP(NP), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_div_we    (cfg_div_we),
    .cfg_div_data  (cfg_div_data),
    .cfg_mode_we   (cfg_mode_we),
    .cfg_mode_data (cfg_mode_data),
    .thread_active (thread_active),
    .timer_wake    (timer_wake),
    .port_wake     (port_wake),
    .core_clk_en   (core_clk_en),
    .standby_stat  (standby_stat),
    .div_count     (div_count)
);

// File: tb/rate_governor_test.sv
`timescale 1ns/1ps
// Directed bench for rate_governor: one task per scenario, each checking itself.
module rate_governor_test;
    localparam int NT = 8, NTM = 4, NP = 4, DW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_div_we = 1'b0;
    logic [DW-1:0]  cfg_div_data = '0;
    logic           cfg_mode_we = 1'b0;
    logic [1:0]     cfg_mode_data = '0;
    logic [NT-1:0]  thread_active = '0;
    logic [NTM-1:0] timer_wake = '0;
    logic [NP-1:0]  port_wake = '0;
    logic           core_clk_en;
    logic           standby_stat;
    logic [DW-1:0]  div_count;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    rate_governor #(.NT(NT), .NTM(NTM), .NP(NP), .DW(DW)) uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_div_we (cfg_div_we), .cfg_div_data (cfg_div_data),
        .cfg_mode_we (cfg_mode_we), .cfg_mode_data (cfg_mode_data),
        .thread_active (thread_active), .timer_wake (timer_wake), .port_wake (port_wake),
        .core_clk_en (core_clk_en), .standby_stat (standby_stat), .div_count (div_count)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        cfg_mode_we = 1'b1; cfg_mode_data = m;
        tick();
        cfg_mode_we = 1'b0;
        tick();
    endtask

    task automatic set_div(input int n);
        cfg_div_we = 1'b1; cfg_div_data = DW'(n);
        tick();
        cfg_div_we = 1'b0;
    endtask

    // Count enables over a window of cycles.
    task automatic count_en(input int cycles, output int pulses);
        pulses = 0;
        for (int i = 0; i < cycles; i++) begin
            if (core_clk_en) pulses++;
            tick();
        end
    endtask

    // Count ticks until an enable is seen.
    task automatic ticks_to_en(output int k);
        k = 0;
        while (!core_clk_en && k < 1000) begin
            tick();
            k++;
        end
    endtask

    task automatic t_reset();
        int p;
        chk("R1 en", core_clk_en, 1);
        chk("R1 status", standby_stat, 0);
        chk("R1 count", div_count, 0);
        set_mode(2'b01);
        chk("R4 status", standby_stat, 1);
        count_en(10, p);
        chk("R4/R1 divider cleared full rate", p, 10);
    endtask

    task automatic t_standby();
        int p;
        set_div(4);
        tick();
        chk("R11 status slow", standby_stat, 1);
        count_en(50, p);
        chk("R3 pulses n=4", p, 10);
    endtask

    task automatic t_hundred();
        int p;
        set_div(99);
        count_en(300, p);
        chk("R12 pulses n=99", p, 3);
    endtask

    task automatic t_forced_fast();
        int p;
        set_mode(2'b00);
        thread_active = '0;
        chk("R2 status", standby_stat, 0);
        count_en(20, p);
        chk("R2 pulses", p, 20);
        chk("R11 count zero when fast", div_count, 0);
    endtask

    task automatic t_reserved();
        int p;
        set_mode(2'b01);
        set_mode(2'b10);
        chk("R7 status", standby_stat, 0);
        count_en(20, p);
        chk("R7 pulses", p, 20);
    endtask

    task automatic t_follow();
        int p;
        set_div(3);
        set_mode(2'b11);
        chk("R5 idle slow", standby_stat, 1);
        count_en(40, p);
        chk("R5 idle pulses", p, 10);
        thread_active = 8'h20;
        tick();
        chk("R5 busy fast", standby_stat, 0);
        count_en(10, p);
        chk("R5 busy pulses", p, 10);
        thread_active = '0;
        tick();
        chk("R5 idle again", standby_stat, 1);
    endtask

    task automatic t_wake();
        timer_wake = 4'b0100;
        tick();
        timer_wake = '0;
        chk("R6 timer wake status", standby_stat, 0);
        chk("R6 timer wake en", core_clk_en, 1);
        tick();
        chk("R6 back to slow", standby_stat, 1);
        chk("R6 reload count", div_count, 3);
        tick();
        port_wake = 4'b0001;
        tick();
        port_wake = '0;
        chk("R6 port wake status", standby_stat, 0);
        tick();
        chk("R6 port back slow", standby_stat, 1);
    endtask

    task automatic t_early_exit();
        int g;
        set_div(9);
        g = 0;
        while (div_count != 5 && g < 50) begin tick(); g++; end
        chk("R8 reached mid period", div_count, 5);
        thread_active = 8'h01;
        tick();
        chk("R8 status", standby_stat, 0);
        chk("R8 en", core_clk_en, 1);
    endtask

    task automatic t_fast_to_slow();
        int k;
        set_div(6);
        tick(); tick();
        chk("R11 still fast", standby_stat, 0);
        thread_active = '0;
        tick();
        chk("R9 status", standby_stat, 1);
        chk("R9 count", div_count, 6);
        chk("R9 en low", core_clk_en, 0);
        ticks_to_en(k);
        chk("R9 gap", k, 6);
    endtask

    task automatic t_reload();
        int k;
        set_div(20);
        chk("R10 load 20", div_count, 20);
        tick(); tick(); tick();
        set_div(3);
        chk("R10 load 3", div_count, 3);
        ticks_to_en(k);
        chk("R10 gap", k, 3);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_standby();
        t_hundred();
        t_forced_fast();
        t_reserved();
        t_follow();
        t_wake();
        t_early_exit();
        t_fast_to_slow();
        t_reload();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule